// File: doc/BRIEF.md
# Chained FIFO Depth Expansion Controller

This block is the token logic that lets several identical FIFO controllers work as one deeper FIFO. The instances form a ring. Each one passes write ownership and read ownership to the next instance through a single-cycle pulse. The write pulse is sent when the instance fills its last local location. The read pulse is sent when it drains its last local location. A strap input marks the lead instance, which holds both tokens when reset ends. Each instance gates the shared write and read requests with the tokens it holds. It exposes its local write and read pointers so that a RAM array (not part of this block) can be addressed.

While reset is asserted, the strap and the two link inputs are decoded and the result is latched. If both link inputs read high, the instance is in a ring, because during reset every instance drives its link outputs high. Any other combination means stand-alone use. In that case the strap and link inputs select fall-through or standard read timing and synchronous or asynchronous almost flags. One output pin is shared. In a ring it carries the write link pulse. In stand-alone use it carries the half-full flag.

All logic runs on one clock with a synchronous active-high reset. This suits a build where the read and write clocks of the ring are the same clock.

Top module: `chain_depth_ctrl`

## Requirements
- R1: While `rst` is high, `wr_link_out`, `rd_link_out` and `xo_hf` are 1 and both pointers are 0. After reset in ring mode, the instance with `lead_strap_n` = 0 holds both tokens and every other instance holds neither.
- R2: The mode is latched from the inputs seen during reset. `wr_link_in` = `rd_link_in` = 1 gives `chained` = 1, `fall_through` = 0 and `sync_almost` = 1. Any other pair gives `chained` = 0, `fall_through` = `lead_strap_n`, and `sync_almost` = 1 only when both link inputs are 0. The mode outputs do not change after reset.
- R3: `wr_en_local` equals `wr_req` while `wr_token` is 1 and is 0 otherwise. The read side works the same way with `rd_req`, `rd_token` and `rd_en_local`.
- R4: Each local enable advances its pointer by one. A pointer at DEPTH-1 wraps to 0.
- R5: A local write at pointer DEPTH-1 in ring mode makes `wr_link_out` 1 for exactly the next cycle. In that same cycle `wr_token` goes to 0.
- R6: A local read at pointer DEPTH-1 in ring mode makes `rd_link_out` 1 for exactly the next cycle. In that same cycle `rd_token` goes to 0.
- R7: In ring mode, `wr_link_in` = 1 after reset gives `wr_token` = 1 from the next cycle. `rd_link_in` and `rd_token` behave the same way.
- R8: In ring mode `xo_hf` follows `wr_link_out`. In stand-alone mode `xo_hf` follows `half_full_in`.
- R9: In stand-alone mode both tokens stay 1, both link outputs stay 0 after reset, and changes on the link inputs have no effect.
- R10: The write and read sides act independently. A write hand-off and a read hand-off may be issued in the same cycle by different instances, and both are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lead_strap_n | input | 1 | Low marks the lead instance of the ring |
| wr_link_in | input | 1 | Write token pulse from the previous instance, or strap when stand-alone |
| rd_link_in | input | 1 | Read token pulse from the previous instance, or strap when stand-alone |
| wr_req | input | 1 | Shared write request |
| rd_req | input | 1 | Shared read request |
| half_full_in | input | 1 | Half-full flag from flag logic |
| wr_en_local | output | 1 | Gated local write enable |
| rd_en_local | output | 1 | Gated local read enable |
| wr_ptr | output | AW | Local write pointer |
| rd_ptr | output | AW | Local read pointer |
| wr_token | output | 1 | Instance owns writes |
| rd_token | output | 1 | Instance owns reads |
| wr_link_out | output | 1 | Write token pulse to the next instance |
| rd_link_out | output | 1 | Read token pulse to the next instance |
| xo_hf | output | 1 | Shared pin: write pulse in a ring, half-full when stand-alone |
| chained | output | 1 | Ring mode was decoded at reset |
| fall_through | output | 1 | Fall-through read timing selected |
| sync_almost | output | 1 | Synchronous almost flags selected |

## Verification
A write hand-off and a read hand-off can fall in the same cycle. To provoke this, the bench waits until one instance owns the write token and its neighbour owns the read token, with both pointers at 0. It then raises both requests together for DEPTH cycles. It judges the result by checking two things. Both link pulses must be high in the same cycle. On the next cycle the write token must land on the second instance and the read token on the third, with neither hand-off lost.

// File: rtl/chain_pkg.sv
package chain_pkg;

    typedef struct packed {
        logic chained;
        logic fall_through;
        logic sync_almost;
    } strap_mode_t;

    typedef enum logic {
        TOK_IDLE = 1'b0,
        TOK_HELD = 1'b1
    } tok_state_e;

    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Both link inputs high during reset: the previous instance is also in reset, so a ring exists.
    function automatic strap_mode_t decode_straps(input logic lead_n,
                                                  input logic wx,
                                                  input logic rx);
        strap_mode_t m;
        if (wx && rx) begin
            m.chained      = 1'b1;
            m.fall_through = 1'b0;
            m.sync_almost  = 1'b1;
        end else begin
            m.chained      = 1'b0;
            m.fall_through = lead_n;
            m.sync_almost  = (wx == rx);
        end
        return m;
    endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lead_strap_n,
    input  logic        wx_in,
    input  logic        rx_in,
    output strap_mode_t mode,
    output logic        tok_init
);
    strap_mode_t decoded;
    strap_mode_t mode_q;

    always_comb begin
        decoded  = decode_straps(lead_strap_n, wx_in, rx_in);
        // In a ring only the lead owns tokens; stand-alone always owns them.
        tok_init = decoded.chained ? ~lead_strap_n : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= decoded;
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/token_port.sv
module token_port
    import chain_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = ptr_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chained,
    input  logic          tok_init,
    input  logic          req,
    input  logic          link_in,
    output logic          grant,
    output logic          own,
    output logic [AW-1:0] ptr,
    output logic          link_out
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    tok_state_e    state_q;
    logic [AW-1:0] ptr_q;
    logic          pulse_q;
    logic          at_last;
    logic          hand_off;

    always_comb begin
        own      = (state_q == TOK_HELD);
        grant    = req && own;
        at_last  = (ptr_q == LAST);
        hand_off = grant && at_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= tok_init ? TOK_HELD : TOK_IDLE;
            ptr_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            if (grant) begin
                ptr_q <= at_last ? '0 : ptr_q + 1'b1;
            end
            pulse_q <= chained && hand_off;
            if (chained) begin
                if (hand_off) begin
                    state_q <= TOK_IDLE;
                end else if (link_in) begin
                    state_q <= TOK_HELD;
                end
            end
        end
    end

    assign ptr      = ptr_q;
    // Reset drives the link high so neighbours can detect a ring.
    assign link_out = pulse_q || rst;
endmodule

// File: rtl/chain_depth_ctrl.sv
module chain_depth_ctrl
    import chain_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = ptr_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lead_strap_n,
    input  logic          wr_link_in,
    input  logic          rd_link_in,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          half_full_in,
    output logic          wr_en_local,
    output logic          rd_en_local,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          wr_token,
    output logic          rd_token,
    output logic          wr_link_out,
    output logic          rd_link_out,
    output logic          xo_hf,
    output logic          chained,
    output logic          fall_through,
    output logic          sync_almost
);
    localparam int SIDES = 2;

    strap_mode_t   mode;
    logic          tok_init;
    logic [SIDES-1:0] req_v, lin_v, grant_v, own_v, lout_v;
    logic [AW-1:0] ptr_v [SIDES];

    strap_latch u_straps (
        .clk          (clk),
        .rst          (rst),
        .lead_strap_n (lead_strap_n),
        .wx_in        (wr_link_in),
        .rx_in        (rd_link_in),
        .mode         (mode),
        .tok_init     (tok_init)
    );

    assign req_v = {rd_req, wr_req};
    assign lin_v = {rd_link_in, wr_link_in};

    // Side 0 is the write side, side 1 the read side.
    for (genvar s = 0; s < SIDES; s++) begin : g_side
        token_port #(.DEPTH(DEPTH)) u_port (
            .clk      (clk),
            .rst      (rst),
            .chained  (mode.chained),
            .tok_init (tok_init),
            .req      (req_v[s]),
            .link_in  (lin_v[s]),
            .grant    (grant_v[s]),
            .own      (own_v[s]),
            .ptr      (ptr_v[s]),
            .link_out (lout_v[s])
        );
    end

    assign wr_en_local  = grant_v[0];
    assign rd_en_local  = grant_v[1];
    assign wr_token     = own_v[0];
    assign rd_token     = own_v[1];
    assign wr_ptr       = ptr_v[0];
    assign rd_ptr       = ptr_v[1];
    assign wr_link_out  = lout_v[0];
    assign rd_link_out  = lout_v[1];
    assign chained      = mode.chained;
    assign fall_through = mode.fall_through;
    assign sync_almost  = mode.sync_almost;
    assign xo_hf        = (mode.chained || rst) ? lout_v[0] : half_full_in;
endmodule

// File: rtl/chain_depth_ctrl_chk.sv
module chain_depth_ctrl_chk
    import chain_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = ptr_width(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          lead_strap_n,
    input logic          wr_link_in,
    input logic          rd_link_in,
    input logic          wr_req,
    input logic          rd_req,
    input logic          half_full_in,
    input logic          wr_en_local,
    input logic          rd_en_local,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] rd_ptr,
    input logic          wr_token,
    input logic          rd_token,
    input logic          wr_link_out,
    input logic          rd_link_out,
    input logic          xo_hf,
    input logic          chained,
    input logic          fall_through,
    input logic          sync_almost
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable({chained, fall_through, sync_almost}));

    a_r3_wr_gate: assert property (@(posedge clk) disable iff (rst)
        !wr_token |-> !wr_en_local);

    a_r3_rd_gate: assert property (@(posedge clk) disable iff (rst)
        !rd_token |-> !rd_en_local);

    a_r4_wr_wrap: assert property (@(posedge clk) disable iff (rst)
        wr_link_out |-> wr_ptr == '0);

    a_r5_wr_single: assert property (@(posedge clk) disable iff (rst)
        wr_link_out |=> !wr_link_out);

    a_r5_wr_cause: assert property (@(posedge clk) disable iff (rst)
        wr_link_out |-> $past(wr_en_local) && ($past(wr_ptr) == LAST) && !wr_token);

    a_r6_rd_single: assert property (@(posedge clk) disable iff (rst)
        rd_link_out |=> !rd_link_out);

    a_r6_rd_cause: assert property (@(posedge clk) disable iff (rst)
        rd_link_out |-> $past(rd_en_local) && ($past(rd_ptr) == LAST) && !rd_token);

    a_r7_wr_take: assert property (@(posedge clk) disable iff (rst)
        chained && $rose(wr_token) |-> $past(wr_link_in));

    a_r7_rd_take: assert property (@(posedge clk) disable iff (rst)
        chained && $rose(rd_token) |-> $past(rd_link_in));

    a_r9_solo: assert property (@(posedge clk) disable iff (rst)
        !chained |-> wr_token && rd_token && !wr_link_out && !rd_link_out);
endmodule

bind chain_depth_ctrl chain_depth_ctrl_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_chain_depth_ctrl.sv
module tb_chain_depth_ctrl;
    localparam int DEPTH = 4;
    localparam int AW = 2;
    localparam int NV = 15;
    // {wr_req, rd_req, exp wr tokens [c,b,a], exp rd tokens [c,b,a]}
    localparam logic [7:0] VEC [NV] = '{
        8'b10_001_001, 8'b10_001_001, 8'b10_001_001, 8'b10_000_001,
        8'b10_010_001, 8'b10_010_001, 8'b10_010_001, 8'b10_010_001,
        8'b10_000_001, 8'b10_100_001,
        8'b01_100_001, 8'b01_100_001, 8'b01_100_001, 8'b01_100_000,
        8'b01_100_010
    };

    logic clk = 0, rst = 1, wr_req = 0, rd_req = 0;
    logic [2:0] c_wen, c_ren, c_wtok, c_rtok, c_wlo, c_rlo, c_xo, c_chn, c_ft, c_sy;
    logic [AW-1:0] c_wptr [3];
    logic [AW-1:0] c_rptr [3];
    logic s_rst = 1, s_lead = 1, s_wx = 0, s_rx = 0, s_hf = 0, s_wr = 0, s_rd = 0;
    logic s_wen, s_ren, s_wtok, s_rtok, s_wlo, s_rlo, s_xo, s_chn, s_ft, s_sy;
    logic [AW-1:0] s_wptr, s_rptr;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    chain_depth_ctrl #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .lead_strap_n(1'b0), .wr_link_in(c_wlo[2]), .rd_link_in(c_rlo[2]),
        .wr_req(wr_req), .rd_req(rd_req), .half_full_in(1'b1),
        .wr_en_local(c_wen[0]), .rd_en_local(c_ren[0]), .wr_ptr(c_wptr[0]), .rd_ptr(c_rptr[0]),
        .wr_token(c_wtok[0]), .rd_token(c_rtok[0]), .wr_link_out(c_wlo[0]), .rd_link_out(c_rlo[0]),
        .xo_hf(c_xo[0]), .chained(c_chn[0]), .fall_through(c_ft[0]), .sync_almost(c_sy[0]));

    chain_depth_ctrl #(.DEPTH(DEPTH)) dut_b (
        .clk(clk), .rst(rst), .lead_strap_n(1'b1), .wr_link_in(c_wlo[0]), .rd_link_in(c_rlo[0]),
        .wr_req(wr_req), .rd_req(rd_req), .half_full_in(1'b1),
        .wr_en_local(c_wen[1]), .rd_en_local(c_ren[1]), .wr_ptr(c_wptr[1]), .rd_ptr(c_rptr[1]),
        .wr_token(c_wtok[1]), .rd_token(c_rtok[1]), .wr_link_out(c_wlo[1]), .rd_link_out(c_rlo[1]),
        .xo_hf(c_xo[1]), .chained(c_chn[1]), .fall_through(c_ft[1]), .sync_almost(c_sy[1]));

    chain_depth_ctrl #(.DEPTH(DEPTH)) dut_c (
        .clk(clk), .rst(rst), .lead_strap_n(1'b1), .wr_link_in(c_wlo[1]), .rd_link_in(c_rlo[1]),
        .wr_req(wr_req), .rd_req(rd_req), .half_full_in(1'b1),
        .wr_en_local(c_wen[2]), .rd_en_local(c_ren[2]), .wr_ptr(c_wptr[2]), .rd_ptr(c_rptr[2]),
        .wr_token(c_wtok[2]), .rd_token(c_rtok[2]), .wr_link_out(c_wlo[2]), .rd_link_out(c_rlo[2]),
        .xo_hf(c_xo[2]), .chained(c_chn[2]), .fall_through(c_ft[2]), .sync_almost(c_sy[2]));

    chain_depth_ctrl #(.DEPTH(DEPTH)) solo (
        .clk(clk), .rst(s_rst), .lead_strap_n(s_lead), .wr_link_in(s_wx), .rd_link_in(s_rx),
        .wr_req(s_wr), .rd_req(s_rd), .half_full_in(s_hf),
        .wr_en_local(s_wen), .rd_en_local(s_ren), .wr_ptr(s_wptr), .rd_ptr(s_rptr),
        .wr_token(s_wtok), .rd_token(s_rtok), .wr_link_out(s_wlo), .rd_link_out(s_rlo),
        .xo_hf(s_xo), .chained(s_chn), .fall_through(s_ft), .sync_almost(s_sy));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #5;
        end
    endtask

    initial begin
        logic [2:0] pw, pr;
        step(2);
        // R1 reset state
        check("R1 link outs in reset", {c_wlo[0], c_rlo[0], c_xo[0]}, 3'b111);
        check("R1 wr tokens", c_wtok, 3'b001);
        check("R1 rd tokens", c_rtok, 3'b001);
        check("R1 pointers", {c_wptr[1], c_rptr[1]}, 0);
        check("R2 ring decode", {c_chn, c_ft, c_sy}, 9'b111_000_111);
        rst = 0;
        #1;
        check("R1 link outs released", {c_wlo, c_rlo}, 0);
        #1;
        pw = 3'b001;
        pr = 3'b001;
        for (int i = 0; i < NV; i++) begin
            wr_req = VEC[i][7];
            rd_req = VEC[i][6];
            #1;
            check("R3 wr enables", c_wen, {3{VEC[i][7]}} & pw);
            check("R3 rd enables", c_ren, {3{VEC[i][6]}} & pr);
            @(posedge clk);
            #5;
            check("R5 R7 wr tokens", c_wtok, VEC[i][5:3]);
            check("R6 R7 rd tokens", c_rtok, VEC[i][2:0]);
            pw = VEC[i][5:3];
            pr = VEC[i][2:0];
        end
        // R4 R5: third instance fills and returns the write token to the lead
        wr_req = 1;
        rd_req = 0;
        step(2);
        check("R4 ptr advance", c_wptr[2], 2);
        step(2);
        check("R5 pulse", c_wlo[2], 1);
        check("R4 wrap", c_wptr[2], 0);
        check("R5 release", c_wtok[2], 0);
        check("R8 ring pin", c_xo[2], 1);
        step(1);
        check("R5 one cycle", c_wlo[2], 0);
        check("R7 ring return", c_wtok[0], 1);
        // R10 simultaneous write and read hand-offs
        rd_req = 1;
        step(4);
        check("R10 both pulses", {c_wlo[0], c_rlo[1]}, 2'b11);
        wr_req = 0;
        rd_req = 0;
        step(1);
        check("R10 wr to b", c_wtok, 3'b010);
        check("R10 rd to c", c_rtok, 3'b100);
        check("R8 ring ignores half_full", c_xo[1], 0);
        // Stand-alone decode
        step(1);
        s_rst = 0;
        #1;
        check("R2 solo 100", {s_chn, s_ft, s_sy}, 3'b011);
        s_wx = 1;
        s_rx = 1;
        step(1);
        check("R2 R9 mode held", {s_chn, s_ft, s_sy}, 3'b011);
        s_wr = 1;
        for (int k = 0; k < DEPTH + 1; k++) begin
            step(1);
            check("R9 no pulse", {s_wlo, s_rlo, s_wtok, s_rtok}, 4'b0011);
        end
        check("R4 R9 solo wrap", s_wptr, 1);
        s_wr = 0;
        s_hf = 1;
        #1;
        check("R8 solo hf 1", s_xo, 1);
        s_hf = 0;
        #1;
        check("R8 solo hf 0", s_xo, 0);
        s_rst = 1;
        s_lead = 0;
        s_wx = 1;
        s_rx = 0;
        step(2);
        s_rst = 0;
        #1;
        check("R2 solo 010", {s_chn, s_ft, s_sy}, 3'b000);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule